// File: doc/BRIEF.md
# Standby-Aware General-Purpose I/O Port

This block controls a parameterised group of general-purpose pins. Software programs it through a small register bus. For every pin it holds an output latch, a direction bit, a pull-up enable, a digital-input enable and an interrupt-input enable. From these it derives the output-enable, output-level and pull-up controls for each pad. It also conditions the incoming pad level before that level reaches the register read path and the external interrupt logic.

A single standby arming bit works together with a chip-level low-power indication. When both are high, every pin floats and its input is tied low so that an open pad cannot leak current. Pins whose interrupt input is enabled stay live, so they can still wake the device. When a peripheral claims a pin it can take over the pin's output enable and output level, but standby floating still overrides the peripheral.

Top module: `gpio_standby_port`

## Requirements
- R1: After reset the output-latch, direction, pull-up, interrupt-enable and standby registers read 0, and the digital-enable register reads all ones. In this state no pad is driven and no pull-up is on.
- R2: Register addresses are 0 output latch, 1 direction, 2 pull-up, 3 digital enable, 4 interrupt enable and 5 standby arm (bit 0 only, upper bits read 0). A write takes effect at the clock edge and reads back the same value. Unmapped addresses read 0 and writes to them change nothing.
- R3: When standby is not forcing and no override is active, a pin's output enable equals its direction bit (1 = output) and its output level equals its latch bit.
- R4: A read of address 0 returns the latch bit for pins with direction 1 and the conditioned pad input for pins with direction 0.
- R5: The pull-up of a pin is on only when the pull-up bit is 1, the pin is not driven, it is not analog and standby is not forcing.
- R6: A pin is analog when its direction bit is 0 and its digital-enable bit is 0. Its conditioned input is then 0.
- R7: With the standby bit at 1 and lowPower high, every output enable is 0, whatever the direction and override inputs are.
- R8: In that forced state, pins with interrupt enable 0 present conditioned input 0. Pins with interrupt enable 1 still pass the pad level.
- R9: With the standby bit at 0, lowPower has no effect on any pad output or conditioned input.
- R10: Outside forced standby, an asserted peripheral override bit sets that pin's output enable to 1 and its output level to the peripheral's level.
- R11: The interrupt-logic input carries the conditioned pad level for every pin, output pins included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Register write strobe |
| busWdata | input | WIDTH | Write data |
| busRdata | output | WIDTH | Read data for busAddr (combinational) |
| lowPower | input | 1 | Device is in stop or watch mode |
| perOe | input | WIDTH | Peripheral output-enable override per pin |
| perOut | input | WIDTH | Peripheral output level per pin |
| padIn | input | WIDTH | Level seen at each pad |
| padOe | output | WIDTH | Pad driver enable |
| padOut | output | WIDTH | Pad output level |
| padPullUp | output | WIDTH | Pad pull-up enable |
| intIn | output | WIDTH | Conditioned level to interrupt logic |

## Verification
The bench uses the default WIDTH of 8 and ADDR_W of 3. With 8 pins, each configuration can give every pin its own mix of direction, analog selection, interrupt enable and override, so all the priority combinations show up side by side in a single vector. The 3-bit address also leaves the codes 6 and 7 unmapped, which lets the bench check the read-zero and write-ignored behaviour of unmapped addresses.

// File: rtl/gpio_standby_pkg.sv
package gpio_standby_pkg;

  typedef enum logic [2:0] {
    SEL_LATCH  = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_PULL   = 3'd2,
    SEL_DIGEN  = 3'd3,
    SEL_INTEN  = 3'd4,
    SEL_STBY   = 3'd5,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrLatch;
    logic    wrDir;
    logic    wrPull;
    logic    wrDigEn;
    logic    wrIntEn;
    logic    wrStby;
    regSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/gpio_standby_ctrl.sv
module gpio_standby_ctrl
  import gpio_standby_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output portStrobe_t       strobe
);
  localparam int SEL_W = $bits(regSel_e);

  regSel_e hit;

  // Decode the address to a register select; anything outside 0..5 maps to none.
  always_comb begin
    hit = SEL_NONE;
    for (int k = 0; k <= 5; k++) begin
      if (busAddr == ADDR_W'(k)) hit = regSel_e'(SEL_W'(k));
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = hit;
    strobe.wrLatch = busWrEn && (hit == SEL_LATCH);
    strobe.wrDir   = busWrEn && (hit == SEL_DIR);
    strobe.wrPull  = busWrEn && (hit == SEL_PULL);
    strobe.wrDigEn = busWrEn && (hit == SEL_DIGEN);
    strobe.wrIntEn = busWrEn && (hit == SEL_INTEN);
    strobe.wrStby  = busWrEn && (hit == SEL_STBY);
  end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice (
  input  logic dirBit,
  input  logic latchBit,
  input  logic pullBit,
  input  logic digEnBit,
  input  logic intEnBit,
  input  logic forceHiZ,
  input  logic perOeBit,
  input  logic perOutBit,
  input  logic padInBit,
  output logic oeBit,
  output logic outBit,
  output logic pullUpBit,
  output logic condInBit
);
  logic driveReq;
  logic isAnalog;
  logic clampLow;

  always_comb begin
    driveReq  = perOeBit | dirBit;
    isAnalog  = ~dirBit & ~digEnBit;
    clampLow  = forceHiZ & ~intEnBit;
    oeBit     = driveReq & ~forceHiZ;
    outBit    = perOeBit ? perOutBit : latchBit;
    pullUpBit = pullBit & ~driveReq & ~isAnalog & ~forceHiZ;
    condInBit = padInBit & ~isAnalog & ~clampLow;
  end
endmodule

// File: rtl/gpio_standby_dp.sv
module gpio_standby_dp
  import gpio_standby_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic             lowPower,
  input  logic [WIDTH-1:0] perOe,
  input  logic [WIDTH-1:0] perOut,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullUp,
  output logic [WIDTH-1:0] intIn,
  output logic             forceHiZ,
  output logic [WIDTH-1:0] intEnBits
);
  logic [WIDTH-1:0] latchReg, dirReg, pullReg, digEnReg, intEnReg;
  logic             stbyReg;
  logic [WIDTH-1:0] condIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
      dirReg   <= '0;
      pullReg  <= '0;
      digEnReg <= '1;
      intEnReg <= '0;
      stbyReg  <= 1'b0;
    end else begin
      if (strobe.wrLatch) latchReg <= busWdata;
      if (strobe.wrDir)   dirReg   <= busWdata;
      if (strobe.wrPull)  pullReg  <= busWdata;
      if (strobe.wrDigEn) digEnReg <= busWdata;
      if (strobe.wrIntEn) intEnReg <= busWdata;
      if (strobe.wrStby)  stbyReg  <= busWdata[0];
    end
  end

  assign forceHiZ  = stbyReg & lowPower;
  assign intEnBits = intEnReg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_slice u_slice (
      .dirBit    (dirReg[i]),
      .latchBit  (latchReg[i]),
      .pullBit   (pullReg[i]),
      .digEnBit  (digEnReg[i]),
      .intEnBit  (intEnReg[i]),
      .forceHiZ  (forceHiZ),
      .perOeBit  (perOe[i]),
      .perOutBit (perOut[i]),
      .padInBit  (padIn[i]),
      .oeBit     (padOe[i]),
      .outBit    (padOut[i]),
      .pullUpBit (padPullUp[i]),
      .condInBit (condIn[i])
    );
  end

  assign intIn = condIn;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_LATCH: busRdata = (dirReg & latchReg) | (~dirReg & condIn);
      SEL_DIR:   busRdata = dirReg;
      SEL_PULL:  busRdata = pullReg;
      SEL_DIGEN: busRdata = digEnReg;
      SEL_INTEN: busRdata = intEnReg;
      SEL_STBY:  busRdata = {{(WIDTH-1){1'b0}}, stbyReg};
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_standby_port.sv
module gpio_standby_port
  import gpio_standby_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic              lowPower,
  input  logic [WIDTH-1:0]  perOe,
  input  logic [WIDTH-1:0]  perOut,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padPullUp,
  output logic [WIDTH-1:0]  intIn
);
  portStrobe_t      strobe;
  logic             forceHiZ;
  logic [WIDTH-1:0] intEnBits;

  gpio_standby_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_standby_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .lowPower  (lowPower),
    .perOe     (perOe),
    .perOut    (perOut),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullUp (padPullUp),
    .intIn     (intIn),
    .forceHiZ  (forceHiZ),
    .intEnBits (intEnBits)
  );
endmodule

// File: rtl/gpio_standby_port_chk.sv
module gpio_standby_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [WIDTH-1:0]  busWdata,
  input logic              lowPower,
  input logic [WIDTH-1:0]  perOe,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padPullUp,
  input logic [WIDTH-1:0]  intIn,
  input logic              forceHiZ,
  input logic [WIDTH-1:0]  intEnBits
);
  assert_hiz_oe_R7: assert property (@(posedge clk) disable iff (!rstN)
    forceHiZ |-> (padOe == '0));

  assert_hiz_nopull_R7: assert property (@(posedge clk) disable iff (!rstN)
    forceHiZ |-> (padPullUp == '0));

  assert_clamp_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    forceHiZ |-> ((intIn & ~intEnBits) == '0));

  assert_override_oe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !forceHiZ |-> ((padOe & perOe) == perOe));

  assert_pull_not_driven_R5: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padOe) == '0);

  assert_arm_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(5)) |=> (forceHiZ == ($past(busWdata[0]) && lowPower)));
endmodule

bind gpio_standby_port gpio_standby_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWdata  (busWdata),
  .lowPower  (lowPower),
  .perOe     (perOe),
  .padOe     (padOe),
  .padPullUp (padPullUp),
  .intIn     (intIn),
  .forceHiZ  (forceHiZ),
  .intEnBits (intEnBits)
);

// File: tb/gpio_standby_port_tb.sv
`timescale 1ns/1ps
module gpio_standby_port_tb;
  localparam int W = 8;
  localparam int A = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [A-1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata;
  logic lowPower = 1'b0;
  logic [W-1:0] perOe = '0, perOut = '0, padIn = '0;
  logic [W-1:0] padOe, padOut, padPullUp, intIn;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  gpio_standby_port #(.WIDTH(W), .ADDR_W(A)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .lowPower(lowPower),
    .perOe(perOe), .perOut(perOut), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .padPullUp(padPullUp), .intIn(intIn)
  );

  typedef struct packed {
    logic [W-1:0] dir, latch, pull, digEn, intEn;
    logic         stby;
  } cfg_t;

  typedef struct packed {
    logic         lp;
    logic [W-1:0] pOe, pOut, pin;
  } vec_t;

  localparam cfg_t CFGS [2] = '{
    '{8'hF0, 8'hA5, 8'hFF, 8'hFC, 8'h0A, 1'b1},
    '{8'h3C, 8'h5A, 8'hC3, 8'h0F, 8'hF0, 1'b0}
  };

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h00, 8'h00, 8'hFF},
    '{1'b0, 8'h00, 8'h00, 8'h5A},
    '{1'b0, 8'h81, 8'hFF, 8'hC3},
    '{1'b1, 8'h00, 8'h00, 8'hFF},
    '{1'b1, 8'h81, 8'h01, 8'hA5},
    '{1'b1, 8'h00, 8'h00, 8'h0F},
    '{1'b0, 8'h0F, 8'h05, 8'h96}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [W-1:0] val);
    @(negedge clk);
    busAddr = A'(addr); busWdata = val; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int addr, output logic [W-1:0] val);
    busAddr = A'(addr);
    #1 val = busRdata;
  endtask

  task automatic loadCfg(input cfg_t c);
    busWrite(0, c.latch);
    busWrite(1, c.dir);
    busWrite(2, c.pull);
    busWrite(3, c.digEn);
    busWrite(4, c.intEn);
    busWrite(5, {{(W-1){1'b0}}, c.stby});
  endtask

  // Expected port behaviour, built from the requirement list.
  task automatic checkVector(input cfg_t c, input vec_t v, input string tag);
    logic forced;
    logic [W-1:0] eOe, eOut, ePull, eAna, eClamp, eCond, eRd, rd;
    forced = c.stby & v.lp;
    eOe    = forced ? '0 : (v.pOe | c.dir);
    eOut   = (v.pOe & v.pOut) | (~v.pOe & c.latch);
    eAna   = ~c.dir & ~c.digEn;
    ePull  = forced ? '0 : (c.pull & ~(v.pOe | c.dir) & ~eAna);
    eClamp = forced ? ~c.intEn : '0;
    eCond  = v.pin & ~eAna & ~eClamp;
    eRd    = (c.dir & c.latch) | (~c.dir & eCond);
    @(negedge clk);
    lowPower = v.lp; perOe = v.pOe; perOut = v.pOut; padIn = v.pin;
    busRead(0, rd);
    check({tag, " padOe R3/R7/R10"}, padOe, eOe);
    check({tag, " padOut R3/R10"}, padOut, eOut);
    check({tag, " pull R5/R6"}, padPullUp, ePull);
    check({tag, " intIn R6/R8/R11"}, intIn, eCond);
    check({tag, " read R4/R8"}, rd, eRd);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] rd, oeHold, outHold;
    repeat (3) @(negedge clk);
    // R1 reset values while held and after release
    check("R1 padOe in reset", padOe, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pull after reset", padPullUp, 8'h00);
    busRead(1, rd); check("R1 dir reset", rd, 8'h00);
    busRead(3, rd); check("R1 digEn reset", rd, 8'hFF);
    busRead(5, rd); check("R1 stby reset", rd, 8'h00);
    padIn = 8'h3C;
    busRead(0, rd); check("R1 R4 input read after reset", rd, 8'h3C);

    // Table walk over two configurations
    for (int c = 0; c < 2; c++) begin
      loadCfg(CFGS[c]);
      busRead(2, rd); check("R2 pull readback", rd, CFGS[c].pull);
      busRead(4, rd); check("R2 intEn readback", rd, CFGS[c].intEn);
      busRead(5, rd); check("R2 stby readback", rd, {7'd0, CFGS[c].stby});
      for (int v = 0; v < 8; v++) checkVector(CFGS[c], VECS[v], $sformatf("cfg%0d vec%0d", c, v));
    end

    // R2 unmapped address: reads zero, write changes nothing
    busWrite(6, 8'hFF);
    busWrite(7, 8'hFF);
    busRead(6, rd); check("R2 unmapped read", rd, 8'h00);
    busRead(1, rd); check("R2 unmapped write ignored dir", rd, CFGS[1].dir);
    busWrite(5, 8'hFE);
    busRead(5, rd); check("R2 stby upper bits", rd, 8'h00);

    // R9: standby bit 0, toggling lowPower leaves everything unchanged
    @(negedge clk);
    perOe = '0; padIn = 8'hFF; lowPower = 1'b0;
    #1 oeHold = padOe; outHold = padOut;
    lowPower = 1'b1;
    #1 check("R9 oe unchanged", padOe, oeHold);
    check("R9 out unchanged", padOut, outHold);
    check("R9 input unchanged", intIn, 8'hFF & ~(~CFGS[1].dir & ~CFGS[1].digEn));

    // R7/R10: override does not beat forced standby; R8 live interrupt pin
    busWrite(1, 8'hFF);
    busWrite(4, 8'h80);
    busWrite(5, 8'h01);
    @(negedge clk);
    perOe = 8'hFF; perOut = 8'hFF; padIn = 8'hFF;
    #1 check("R7 override loses to standby", padOe, 8'h00);
    check("R8 only interrupt pin live", intIn, 8'h80);
    lowPower = 1'b0;
    #1 check("R10 override drives after wake", padOe, 8'hFF);
    check("R11 output pins feed interrupt", intIn, 8'hFF);

    // R6: analog pin with pull-up bit set gets no pull and reads 0
    busWrite(1, 8'h00);
    busWrite(2, 8'hFF);
    busWrite(3, 8'hF0);
    @(negedge clk);
    perOe = '0; padIn = 8'hFF;
    #1 check("R6 R5 analog pull off", padPullUp, 8'hF0);
    busRead(0, rd); check("R6 analog read zero", rd, 8'hF0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule